// File: doc/BRIEF.md
# Sector decoder control sequencer

This block is the control core of a CD-ROM sector decoder. A host writes an 8-bit control word. The block watches the incoming sector byte stream, which marks the first byte of each block with a start strobe. From these two inputs it does four things. It decides which blocks are written into the buffer memory. It advances a block pointer for every block that is stored. It captures the header bytes that follow the sync field. It raises a level-sensitive decoder interrupt. When correction is enabled, the block hands each finished block to an external corrector and holds the interrupt back until that corrector reports completion.

Changes to buffer writing are applied only at a block boundary. The pointer and the write address therefore always describe whole blocks. A look-ahead bit selects which header is presented. With the bit clear, the outputs show the header and pointer of the block that raised the interrupt. With the bit set, they show the newest block whose header has arrived. The correction datapath, the buffer RAM and the host bus are outside the block. They are reached through plain request/done, write-port and register-write signals.

Control word bits: bit 0 enables decoding, bit 1 selects look-ahead, bit 2 enables buffer writes, bit 3 enables correction, bit 4 is test mode. Bits 5 to 7 are stored only.

Top module: `sector_seq`

## Requirements
- R1: A synchronous reset sets `ctrl_q`, `irq`, `irq_ovr`, `blk_ptr`, `buf_we` and `ecc_req` to 0.
- R2: While bit 0 is 0, no interrupt is raised and no correction is requested. Buffer writes and the pointer still follow bit 2.
- R3: Buffer writing takes its enable from bit 2 as it stands on the start-strobe byte (index 0). A block that began with the enable clear writes nothing, even if bit 2 is set partway through it.
- R4: `blk_ptr` advances by one on the last byte (index BLK_LEN-1) of each block stored in the buffer and wraps at 2^PTR_W. In every other case it holds its value.
- R5: Each buffer write carries `buf_addr` one above the previous write's address, modulo 2^ADDR_W, starting from 0 after reset.
- R6: With bits 0 and 3 set, a one-cycle `ecc_req` follows the last byte of a block. `irq` rises only in the cycle after `ecc_done` is sampled high.
- R7: With bit 0 set and bit 3 clear, `irq` is high in the cycle after the last byte of a block.
- R8: The header is the HDR_BYTES bytes at indices HDR_OFS upward, with the first byte most significant. With bit 1 clear, `hdr_out`/`cur_addr` show the block that raised the latest interrupt. With bit 1 set, they show the newest block whose header is complete, together with its pointer value.
- R9: Clearing bit 2 partway through a block lets that block finish writing all its bytes. The new value shows on `ctrl_q` at once.
- R10: `irq` stays high until a cycle with `irq_clr` high. That cycle also clears `irq_ovr`.
- R11: An interrupt event that arrives while `irq` is still high sets `irq_ovr`.
- R12: With bit 4 set, decoding is suppressed exactly as with bit 0 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| ctrl_q | output | 8 | Stored control word |
| irq_clr | input | 1 | Interrupt clear strobe |
| in_valid | input | 1 | Sector byte valid |
| in_sop | input | 1 | First byte of a block |
| in_data | input | 8 | Sector byte |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | ADDR_W | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| blk_ptr | output | PTR_W | Block pointer |
| hdr_out | output | 8*HDR_BYTES | Selected header |
| cur_addr | output | PTR_W | Pointer value of the selected block |
| ecc_req | output | 1 | Correction request pulse |
| ecc_done | input | 1 | Correction complete |
| irq | output | 1 | Decoder interrupt, level |
| irq_ovr | output | 1 | Interrupt overrun flag |

## Verification
The bench builds the block with BLK_LEN=24, HDR_OFS=4, HDR_BYTES=4, PTR_W=4 and ADDR_W=6. Short blocks keep each scenario to a few dozen cycles. The 4-bit pointer wraps after sixteen stored blocks, and the 6-bit write address wraps in under three blocks, so both wrap points are reached. A corrector model with an adjustable delay exposes the window in which the interrupt must be held back.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  localparam int CB_DEC  = 0;
  localparam int CB_LA   = 1;
  localparam int CB_WR   = 2;
  localparam int CB_ECC  = 3;
  localparam int CB_TEST = 4;

  typedef enum logic {ST_IDLE, ST_BUSY} seq_st_t;
endpackage

// File: rtl/sseq_ctrl_reg.sv
module sseq_ctrl_reg #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (cfg_we) ctrl_q <= cfg_wdata;
  end

  // R1: reset leaves the control word at zero
  p_rst_clear_r1: assert property (@(posedge clk) rst |=> (ctrl_q == '0));
endmodule

// File: rtl/sseq_framer.sv
module sseq_framer #(
  parameter int BLK_LEN   = 2352,
  parameter int HDR_OFS   = 12,
  parameter int HDR_BYTES = 4,
  parameter int PTR_W     = 24,
  parameter int ADDR_W    = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_req,
  input  logic                   in_valid,
  input  logic                   in_sop,
  input  logic [7:0]             in_data,
  output logic                   buf_we,
  output logic [ADDR_W-1:0]      buf_addr,
  output logic [7:0]             buf_wdata,
  output logic [PTR_W-1:0]       blk_ptr,
  output logic [8*HDR_BYTES-1:0] nxt_hdr,
  output logic [PTR_W-1:0]       nxt_addr,
  output logic                   blk_end
);
  localparam int HW       = 8 * HDR_BYTES;
  localparam int IDX_W    = $clog2(BLK_LEN);
  localparam int HDR_LAST = HDR_OFS + HDR_BYTES - 1;

  logic [IDX_W-1:0]  idx_q, idx_now;
  logic              in_blk_q, wr_act_q, wr_now, byte_ok, in_hdr;
  logic [HW-9:0]     sh_q;
  logic [HW-1:0]     sh_next;
  logic [ADDR_W-1:0] wa_q;

  assign byte_ok = in_valid && (in_sop || in_blk_q);
  assign idx_now = in_sop ? '0 : idx_q;
  assign wr_now  = in_sop ? wr_req : wr_act_q;
  assign blk_end = byte_ok && (idx_now == IDX_W'(BLK_LEN - 1));
  assign in_hdr  = (idx_now >= IDX_W'(HDR_OFS)) && (idx_now <= IDX_W'(HDR_LAST));
  assign sh_next = {sh_q, in_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      in_blk_q  <= 1'b0;
      wr_act_q  <= 1'b0;
      sh_q      <= '0;
      wa_q      <= '0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
      blk_ptr   <= '0;
      nxt_hdr   <= '0;
      nxt_addr  <= '0;
    end else begin
      buf_we <= byte_ok && wr_now;
      if (byte_ok) begin
        idx_q    <= idx_now + IDX_W'(1);
        in_blk_q <= !blk_end;
        if (in_sop) wr_act_q <= wr_req;
        if (wr_now) begin
          buf_addr  <= wa_q;
          buf_wdata <= in_data;
          wa_q      <= wa_q + ADDR_W'(1);
        end
        if (in_hdr) sh_q <= sh_next[HW-9:0];
        if (idx_now == IDX_W'(HDR_LAST)) begin
          nxt_hdr  <= sh_next;
          nxt_addr <= blk_ptr;
        end
        if (blk_end && wr_now) blk_ptr <= blk_ptr + PTR_W'(1);
      end
    end
  end

  // R3: a block that started without write enable produces no buffer writes
  p_late_start_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sop && !wr_act_q) |=> !buf_we);
  // R4: pointer frozen while the current block is not being stored
  p_ptr_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_act_q |=> $stable(blk_ptr));
  // R5: back-to-back writes use consecutive addresses
  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (buf_we && in_valid && !in_sop && wr_act_q) |=>
      (buf_addr == $past(buf_addr) + ADDR_W'(1)));
endmodule

// File: rtl/sseq_irq.sv
module sseq_irq
  import sseq_pkg::*;
#(
  parameter int HW    = 32,
  parameter int PTR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_act,
  input  logic             ecc_en,
  input  logic             look_ahead,
  input  logic             blk_end,
  input  logic [HW-1:0]    blk_hdr,
  input  logic [PTR_W-1:0] blk_addr,
  input  logic             ecc_done,
  input  logic             irq_clr,
  output logic             ecc_req,
  output logic             irq,
  output logic             irq_ovr,
  output logic [HW-1:0]    hdr_out,
  output logic [PTR_W-1:0] cur_addr
);
  seq_st_t          st_q;
  logic [HW-1:0]    hold_hdr, cur_hdr;
  logic [PTR_W-1:0] hold_adr, cur_adr_q;
  logic             direct, fin, evt;

  assign direct = blk_end && dec_act && !ecc_en;
  assign fin    = (st_q == ST_BUSY) && ecc_done && dec_act;
  assign evt    = direct || fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ecc_req   <= 1'b0;
      hold_hdr  <= '0;
      hold_adr  <= '0;
      cur_hdr   <= '0;
      cur_adr_q <= '0;
      irq       <= 1'b0;
      irq_ovr   <= 1'b0;
    end else begin
      ecc_req <= 1'b0;
      if (blk_end && dec_act && ecc_en) begin
        st_q     <= ST_BUSY;
        ecc_req  <= 1'b1;
        hold_hdr <= blk_hdr;
        hold_adr <= blk_addr;
      end else if (st_q == ST_BUSY && ecc_done) begin
        st_q <= ST_IDLE;
      end
      if (direct) begin
        cur_hdr   <= blk_hdr;
        cur_adr_q <= blk_addr;
      end else if (fin) begin
        cur_hdr   <= hold_hdr;
        cur_adr_q <= hold_adr;
      end
      irq     <= evt || (irq && !irq_clr);
      irq_ovr <= (evt && irq && !irq_clr) || (irq_ovr && !irq_clr);
    end
  end

  assign hdr_out  = look_ahead ? blk_hdr  : cur_hdr;
  assign cur_addr = look_ahead ? blk_addr : cur_adr_q;

  // R1: reset clears the interrupt state
  p_rst_irq_r1: assert property (@(posedge clk) rst |=> (!irq && !irq_ovr));
  // R2: no new interrupt while decoding is inactive
  p_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !dec_act |=> !$rose(irq));
  // R6: request is one cycle wide
  p_req_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    ecc_req |=> !ecc_req);
  // R6: interrupt withheld while the corrector is still running
  p_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BUSY && !ecc_done && !blk_end) |=> !$rose(irq));
  // R10: interrupt holds until cleared
  p_level_r10: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
  // R11: overrun only rises on top of a pending interrupt
  p_ovr_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ovr) |-> $past(irq));
endmodule

// File: rtl/sector_seq.sv
module sector_seq
  import sseq_pkg::*;
#(
  parameter int BLK_LEN   = 2352,
  parameter int HDR_OFS   = 12,
  parameter int HDR_BYTES = 4,
  parameter int PTR_W     = 24,
  parameter int ADDR_W    = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [7:0]             cfg_wdata,
  output logic [7:0]             ctrl_q,
  input  logic                   irq_clr,
  input  logic                   in_valid,
  input  logic                   in_sop,
  input  logic [7:0]             in_data,
  output logic                   buf_we,
  output logic [ADDR_W-1:0]      buf_addr,
  output logic [7:0]             buf_wdata,
  output logic [PTR_W-1:0]       blk_ptr,
  output logic [8*HDR_BYTES-1:0] hdr_out,
  output logic [PTR_W-1:0]       cur_addr,
  output logic                   ecc_req,
  input  logic                   ecc_done,
  output logic                   irq,
  output logic                   irq_ovr
);
  localparam int HW = 8 * HDR_BYTES;

  logic [HW-1:0]    nxt_hdr;
  logic [PTR_W-1:0] nxt_addr;
  logic             blk_end, dec_act;

  sseq_ctrl_reg #(.CW(8)) u_reg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q)
  );

  assign dec_act = ctrl_q[CB_DEC] && !ctrl_q[CB_TEST];

  sseq_framer #(
    .BLK_LEN(BLK_LEN), .HDR_OFS(HDR_OFS), .HDR_BYTES(HDR_BYTES),
    .PTR_W(PTR_W), .ADDR_W(ADDR_W)
  ) u_frm (
    .clk(clk), .rst(rst), .wr_req(ctrl_q[CB_WR]),
    .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .blk_ptr(blk_ptr), .nxt_hdr(nxt_hdr), .nxt_addr(nxt_addr), .blk_end(blk_end)
  );

  sseq_irq #(.HW(HW), .PTR_W(PTR_W)) u_irq (
    .clk(clk), .rst(rst), .dec_act(dec_act), .ecc_en(ctrl_q[CB_ECC]),
    .look_ahead(ctrl_q[CB_LA]), .blk_end(blk_end), .blk_hdr(nxt_hdr),
    .blk_addr(nxt_addr), .ecc_done(ecc_done), .irq_clr(irq_clr),
    .ecc_req(ecc_req), .irq(irq), .irq_ovr(irq_ovr),
    .hdr_out(hdr_out), .cur_addr(cur_addr)
  );
endmodule

// File: tb/sim_sector_seq.sv
module sim_sector_seq;
  localparam int BL = 24, HO = 4, HB = 4, PW = 4, AW = 6, HW = 32;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic          cfg_we = 0, irq_clr = 0, in_valid = 0, in_sop = 0, ecc_done;
  logic [7:0]    cfg_wdata = 0, in_data = 0, ctrl_q, buf_wdata;
  logic          buf_we, ecc_req, irq, irq_ovr;
  logic [AW-1:0] buf_addr;
  logic [PW-1:0] blk_ptr, cur_addr;
  logic [HW-1:0] hdr_out;

  sector_seq #(.BLK_LEN(BL), .HDR_OFS(HO), .HDR_BYTES(HB), .PTR_W(PW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q),
    .irq_clr(irq_clr), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .blk_ptr(blk_ptr),
    .hdr_out(hdr_out), .cur_addr(cur_addr), .ecc_req(ecc_req), .ecc_done(ecc_done),
    .irq(irq), .irq_ovr(irq_ovr)
  );

  int checks = 0, fails = 0, wr_total = 0, req_total = 0, done_dly = 2;
  logic [AW-1:0] exp_wa = '0;

  // vector: [11:4] control word, [3] irq, [2] one request, [1] block stored, [0] pointer step
  localparam logic [11:0] VEC [0:7] = '{12'h05B, 12'h018, 12'h0DF, 12'h043,
                                        12'h0C3, 12'h153, 12'h09C, 12'h063};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [HW-1:0] hdr_of(input logic [7:0] s);
    logic [HW-1:0] h = '0;
    for (int j = 0; j < HB; j++) h = {h[HW-9:0], 8'(s + 8'(HO + j))};
    return h;
  endfunction

  // R5 monitor: every write address follows the previous one
  always @(posedge clk) begin
    if (rst) exp_wa = '0;
    else if (buf_we) begin
      checks++;
      wr_total++;
      if (buf_addr !== exp_wa) begin
        fails++;
        $display("FAIL R5 buf_addr actual=%0h expected=%0h", buf_addr, exp_wa);
      end
      exp_wa = exp_wa + 1'b1;
    end
  end

  // corrector model
  initial begin
    ecc_done = 1'b0;
    forever begin
      @(posedge clk);
      if (ecc_req === 1'b1) begin
        req_total++;
        repeat (done_dly) @(negedge clk);
        ecc_done = 1'b1;
        @(negedge clk);
        ecc_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic clr_irq;
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic send(input logic [7:0] seed, input int first, input int last,
                      input int mid_at, input logic [7:0] mid_v);
    for (int i = first; i <= last; i++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (i == 0); in_data = seed + 8'(i);
      cfg_we = (i == mid_at); cfg_wdata = mid_v;
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; cfg_we = 0;
  endtask

  task automatic blk(input logic [7:0] seed);
    send(seed, 0, BL - 1, -1, 8'h00);
    repeat (done_dly + 4) @(negedge clk);
  endtask

  initial begin
    logic [PW-1:0] p0;
    int w0, r0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 ctrl_q", ctrl_q, 0);
    chk("R1 irq", irq, 0);
    chk("R1 irq_ovr", irq_ovr, 0);
    chk("R1 blk_ptr", blk_ptr, 0);
    chk("R1 buf_we/ecc_req", {buf_we, ecc_req}, 0);

    // table walk
    for (int k = 0; k < 8; k++) begin
      logic [7:0] c, s;
      c = VEC[k][11:4];
      s = 8'(k * 16 + 3);
      clr_irq();
      cfg(c);
      p0 = blk_ptr; w0 = wr_total; r0 = req_total;
      blk(s);
      chk($sformatf("R2 R7 R12 irq vec%0d", k), irq, VEC[k][3]);
      chk($sformatf("R6 requests vec%0d", k), req_total - r0, VEC[k][2]);
      chk($sformatf("R3 writes vec%0d", k), wr_total - w0, VEC[k][1] ? BL : 0);
      chk($sformatf("R4 pointer vec%0d", k), blk_ptr, PW'(p0 + PW'(VEC[k][0])));
      if (VEC[k][3] || c[1]) chk($sformatf("R8 header vec%0d", k), hdr_out, hdr_of(s));
    end

    // R8 look-ahead
    cfg(8'h05); clr_irq();
    p0 = blk_ptr;
    blk(8'hA0);
    send(8'hB0, 0, 7, -1, 8'h00);
    chk("R8 hdr current", hdr_out, hdr_of(8'hA0));
    chk("R8 addr current", cur_addr, p0);
    cfg(8'h07);
    chk("R8 hdr look-ahead", hdr_out, hdr_of(8'hB0));
    chk("R8 addr look-ahead", cur_addr, PW'(p0 + 1));
    cfg(8'h05);
    send(8'hB0, 8, BL - 1, -1, 8'h00);
    repeat (3) @(negedge clk);
    chk("R8 hdr after next irq", hdr_out, hdr_of(8'hB0));

    // R3 / R9 pending write enable
    cfg(8'h01);
    blk(8'h11);
    w0 = wr_total;
    send(8'h22, 0, BL - 1, 10, 8'h05);
    repeat (4) @(negedge clk);
    chk("R3 no writes in started block", wr_total - w0, 0);
    chk("R9 ctrl_q updated", ctrl_q, 8'h05);
    w0 = wr_total;
    blk(8'h33);
    chk("R3 writes from next block", wr_total - w0, BL);
    w0 = wr_total;
    send(8'h44, 0, BL - 1, 10, 8'h01);
    repeat (4) @(negedge clk);
    chk("R9 block finishes writing", wr_total - w0, BL);
    w0 = wr_total; p0 = blk_ptr;
    blk(8'h55);
    chk("R4 no writes when disabled", wr_total - w0, 0);
    chk("R4 pointer frozen", blk_ptr, p0);

    // R6 correction wait, R10 level, R11 overrun
    done_dly = 15;
    cfg(8'h0D); clr_irq();
    r0 = req_total;
    send(8'h66, 0, BL - 1, -1, 8'h00);
    repeat (5) @(negedge clk);
    chk("R6 irq held during correction", irq, 0);
    chk("R6 one request", req_total - r0, 1);
    repeat (15) @(negedge clk);
    chk("R6 irq after done", irq, 1);
    repeat (10) @(negedge clk);
    chk("R10 irq still high", irq, 1);
    chk("R11 no overrun yet", irq_ovr, 0);
    done_dly = 2;
    blk(8'h77);
    chk("R11 overrun set", irq_ovr, 1);
    clr_irq();
    chk("R10 irq cleared", irq, 0);
    chk("R10 R11 overrun cleared", irq_ovr, 0);

    // R4 pointer wrap
    cfg(8'h04);
    p0 = blk_ptr;
    for (int b = 0; b < 16; b++) send(8'(b), 0, BL - 1, -1, 8'h00);
    repeat (3) @(negedge clk);
    chk("R4 pointer wrapped", blk_ptr, p0);
    blk(8'h88);
    chk("R4 pointer after wrap", blk_ptr, PW'(p0 + 1));

    // R1 reset mid-run
    cfg(8'h0D);
    blk(8'h99);
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    chk("R1 ctrl_q after reset", ctrl_q, 0);
    chk("R1 irq after reset", {irq, irq_ovr}, 0);
    chk("R1 pointer after reset", blk_ptr, 0);
    finish_run();
  end
endmodule